// File: doc/BRIEF.md
# Parity-Gated Nibble Calculator

This block is a small arithmetic engine wrapped around a 64-entry, 4-bit register file. A start pulse accepts three addresses: two source locations and one destination. The engine then fetches the first source word into operand register A and the second into operand register B, over two consecutive cycles. In the next cycle it captures a 4-bit sum with carry, a 4-bit difference with borrow, and an 8-bit two's-complement product of the two operands. In the last cycle it optionally writes one nibble back to the destination address.

The write-back nibble is picked by a parity test on the upper half of the product. If an odd number of those four bits are set, the product's upper nibble is stored. If the count is even, the external data word is stored instead. An initialization input skips the test and always selects the external word.

While the engine is idle, a host write strobe stores the external word directly into the register file. A separate observation address reads any location at any time. This is how the array is filled before use and how its contents are checked afterwards.

Top module: `calc_core`

## Requirements
- R1: While reset is held and directly after it, `busy` and `done` are 0 and `sum`, `carry`, `diff`, `borrow` and `prod` are all 0.
- R2: The clock edge that sees `start` high while idle fixes the addresses. A is then read from `addr_a` and B from `addr_b`. The results appear on the outputs three edges after the accepting edge.
- R3: `sum` is (A + B) mod 16, and `carry` is the unsigned carry-out of that addition.
- R4: `diff` is (A − B) mod 16, and `borrow` is 1 exactly when A < B taken as unsigned values.
- R5: `prod` is the 8-bit two's-complement product of A and B, each read as a signed 4-bit value in the range −8..7.
- R6: With `init_mode` low, when bits [7:4] of `prod` contain an odd number of ones, those four bits are the write-back word.
- R7: With `init_mode` low, when bits [7:4] of `prod` contain an even number of ones (zero included), `ext_data` is the write-back word.
- R8: With `init_mode` high, the write-back word is `ext_data`, whatever the parity.
- R9: The write-back word is stored at the latched `addr_w` on the fourth edge after start, but only if `wb_en` was high when start was accepted. Otherwise that location keeps its old value.
- R10: While idle, `host_we` high stores `ext_data` at `addr_w` on the next edge. `peek_data` always shows the word stored at `peek_addr`.
- R11: `busy` is high from the edge that accepts start until the write-back edge. `done` is high for exactly one cycle after the write-back edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one fetch-compute-writeback pass (accepted when idle) |
| wb_en | input | 1 | Allow the write-back of this pass (sampled with start) |
| init_mode | input | 1 | Force external data as write-back word |
| host_we | input | 1 | Direct write of ext_data while idle |
| addr_a | input | 6 | Source address of operand A |
| addr_b | input | 6 | Source address of operand B |
| addr_w | input | 6 | Destination address (write-back and host write) |
| ext_data | input | 4 | External data word |
| peek_addr | input | 6 | Observation read address |
| peek_data | output | 4 | Word stored at peek_addr |
| sum | output | 4 | A + B modulo 16 |
| carry | output | 1 | Carry-out of the addition |
| diff | output | 4 | A − B modulo 16 |
| borrow | output | 1 | Set when A < B unsigned |
| prod | output | 8 | Signed product of A and B |
| wb_data | output | 4 | Word selected for write-back |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after write-back |

## Verification
The bench builds the block with its default widths: 4-bit words and 6-bit addresses. With 4-bit words there are only 256 operand pairs, so random passes plus directed pairs reach both extremes of the signed range (−8 × −8, 7 × −8, −1 × 1). Together these pairs produce both parity outcomes of the product's upper nibble. With 6-bit addresses the bench can preload and read back every location of the register file. It also sees destination addresses that coincide with source addresses, so a write-back result feeds a later pass.

// File: rtl/calc_pkg.sv
package calc_pkg;
    localparam int DW    = 4;
    localparam int AW    = 6;
    localparam int PW    = 2 * DW;
    localparam int DEPTH = 1 << AW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LDA,
        ST_LDB,
        ST_CALC,
        ST_WB
    } seq_e;

    typedef struct packed {
        logic [DW-1:0] sum;
        logic          carry;
        logic [DW-1:0] diff;
        logic          borrow;
        logic [PW-1:0] prod;
    } alu_res_t;

    function automatic logic [DW-1:0] pick_wb(input logic init,
                                              input logic [PW-1:0] prod,
                                              input logic [DW-1:0] ext);
        logic [DW-1:0] hi;
        hi = prod[PW-1 -: DW];
        if (init)
            return ext;
        else if (^hi)
            return hi;
        else
            return ext;
    endfunction
endpackage

// File: rtl/calc_regfile.sv
module calc_regfile
    import calc_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_op,
    output logic [DW-1:0] rdata_op,
    input  logic [AW-1:0] raddr_obs,
    output logic [DW-1:0] rdata_obs
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_op  = mem[raddr_op];
    assign rdata_obs = mem[raddr_obs];
endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output alu_res_t      res
);
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] p_full;

    always_comb begin
        a_ext = $signed({{DW{a[DW-1]}}, a});
        b_ext = $signed({{DW{b[DW-1]}}, b});
        p_full = a_ext * b_ext;
        {res.carry, res.sum} = {1'b0, a} + {1'b0, b};
        res.diff   = a - b;
        res.borrow = (a < b);
        res.prod   = p_full;
    end
endmodule

// File: rtl/calc_seq.sv
module calc_seq
    import calc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output seq_e state,
    output logic done
);
    seq_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (start) nxt = ST_LDA;
            ST_LDA:  nxt = ST_LDB;
            ST_LDB:  nxt = ST_CALC;
            ST_CALC: nxt = ST_WB;
            ST_WB:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_WB);
        end
    end

    a_r11_done_once: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/calc_core.sv
module calc_core
    import calc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          wb_en,
    input  logic          init_mode,
    input  logic          host_we,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic [AW-1:0] addr_w,
    input  logic [DW-1:0] ext_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic [DW-1:0] diff,
    output logic          borrow,
    output logic [PW-1:0] prod,
    output logic [DW-1:0] wb_data,
    output logic          busy,
    output logic          done
);
    seq_e          state;
    logic [AW-1:0] ra_q, rb_q, rw_q;
    logic          en_q;
    logic [DW-1:0] op_a, op_b;
    alu_res_t      alu_now, res_q;
    logic [AW-1:0] op_raddr;
    logic [DW-1:0] op_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;

    calc_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .state (state),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q <= '0;
            rb_q <= '0;
            rw_q <= '0;
            en_q <= 1'b0;
            op_a <= '0;
            op_b <= '0;
            res_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                ra_q <= addr_a;
                rb_q <= addr_b;
                rw_q <= addr_w;
                en_q <= wb_en;
            end
            if (state == ST_LDA)  op_a  <= op_rdata;
            if (state == ST_LDB)  op_b  <= op_rdata;
            if (state == ST_CALC) res_q <= alu_now;
        end
    end

    assign op_raddr = (state == ST_LDA) ? ra_q : rb_q;

    calc_alu u_alu (
        .a   (op_a),
        .b   (op_b),
        .res (alu_now)
    );

    assign wb_data   = pick_wb(init_mode, res_q.prod, ext_data);
    assign mem_we    = ((state == ST_WB) && en_q) || ((state == ST_IDLE) && host_we);
    assign mem_waddr = (state == ST_WB) ? rw_q : addr_w;
    assign mem_wdata = (state == ST_WB) ? wb_data : ext_data;

    calc_regfile u_mem (
        .clk       (clk),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .raddr_op  (op_raddr),
        .rdata_op  (op_rdata),
        .raddr_obs (peek_addr),
        .rdata_obs (peek_data)
    );

    assign sum    = res_q.sum;
    assign carry  = res_q.carry;
    assign diff   = res_q.diff;
    assign borrow = res_q.borrow;
    assign prod   = res_q.prod;
    assign busy   = (state != ST_IDLE);

    a_r11_busy_on_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    a_r8_init_forces_ext: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == ST_WB && init_mode) |-> (mem_wdata == ext_data));

    a_r6_product_word_odd: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == ST_WB && mem_wdata != ext_data) |-> (^mem_wdata));

    a_r9_no_write_when_off: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB && !en_q) |-> !mem_we);

    a_r5_product_sign: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB && op_a != '0 && op_b != '0)
            |-> (prod[PW-1] == (op_a[DW-1] ^ op_b[DW-1])));

    a_r3_sum_carry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB) |-> ({carry, sum} == ({1'b0, op_a} + {1'b0, op_b})));
endmodule

// File: tb/sim_calc_core.sv
module sim_calc_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       start, wb_en, init_mode, host_we;
    logic [5:0] addr_a, addr_b, addr_w, peek_addr;
    logic [3:0] ext_data, peek_data, sum, diff, wb_data;
    logic       carry, borrow, busy, done;
    logic [7:0] prod;

    int total = 0;
    int bad   = 0;
    logic [3:0] ref_mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    calc_core u0 (
        .clk(clk), .rst(rst), .start(start), .wb_en(wb_en), .init_mode(init_mode),
        .host_we(host_we), .addr_a(addr_a), .addr_b(addr_b), .addr_w(addr_w),
        .ext_data(ext_data), .peek_addr(peek_addr), .peek_data(peek_data),
        .sum(sum), .carry(carry), .diff(diff), .borrow(borrow), .prod(prod),
        .wb_data(wb_data), .busy(busy), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sgn4(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    function automatic logic [7:0] exp_prod(input logic [3:0] a, input logic [3:0] b);
        return 8'(sgn4(a) * sgn4(b));
    endfunction

    function automatic logic [3:0] exp_wb(input logic init, input logic [3:0] a,
                                          input logic [3:0] b, input logic [3:0] ext);
        logic [7:0] p;
        p = exp_prod(a, b);
        if (init) return ext;
        if (p[7] ^ p[6] ^ p[5] ^ p[4]) return p[7:4];
        return ext;
    endfunction

    task automatic host_write(input logic [5:0] a, input logic [3:0] d);
        @(negedge clk);
        host_we  = 1'b1;
        addr_w   = a;
        ext_data = d;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic do_op(input logic [5:0] ra, input logic [5:0] rb, input logic [5:0] rw,
                         input logic en, input logic init, input logic [3:0] ext);
        logic [3:0] a, b, w;
        a = ref_mem[ra];
        b = ref_mem[rb];
        w = exp_wb(init, a, b, ext);
        @(negedge clk);
        addr_a = ra; addr_b = rb; addr_w = rw;
        wb_en = en; init_mode = init; ext_data = ext; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R11 busy after start", int'(busy), 1);
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R3 sum", int'(sum), int'(4'(a + b)));
        check("R3 carry", int'(carry), (int'(a) + int'(b)) > 15 ? 1 : 0);
        check("R2/R4 diff", int'(diff), int'(4'(a - b)));
        check("R4 borrow", int'(borrow), (a < b) ? 1 : 0);
        check("R5 prod", int'(prod), int'(exp_prod(a, b)));
        if (init) check("R8 wb word", int'(wb_data), int'(w));
        else if (^prod[7:4]) check("R6 wb word", int'(wb_data), int'(w));
        else check("R7 wb word", int'(wb_data), int'(w));
        check("R11 no early done", int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        check("R11 done pulse", int'(done), 1);
        check("R11 idle after wb", int'(busy), 0);
        if (en) ref_mem[rw] = w;
        peek_addr = rw;
        #1;
        check("R9 stored word", int'(peek_data), int'(ref_mem[rw]));
        @(negedge clk);
        check("R11 done drops", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd577);
        rst = 1'b1; start = 1'b0; wb_en = 1'b0; init_mode = 1'b0; host_we = 1'b0;
        addr_a = '0; addr_b = '0; addr_w = '0; ext_data = '0; peek_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 prod", int'(prod), 0);
        check("R1 sum/diff", int'({sum, diff, carry, borrow}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after release", int'(busy), 0);

        for (int i = 0; i < 64; i++) host_write(6'(i), 4'($urandom));
        for (int i = 0; i < 64; i++) begin
            peek_addr = 6'(i);
            #1;
            check("R10 host write", int'(peek_data), int'(ref_mem[i]));
        end

        // directed pairs: signed extremes, both parity outcomes, init, write disabled
        host_write(6'd60, 4'h8); host_write(6'd61, 4'h8);
        do_op(6'd60, 6'd61, 6'd62, 1'b1, 1'b0, 4'h5);   // 0x40: odd, stores 4
        host_write(6'd60, 4'h7); host_write(6'd61, 4'h7);
        do_op(6'd60, 6'd61, 6'd62, 1'b1, 1'b0, 4'ha);   // 0x31: even, stores ext
        host_write(6'd60, 4'h7); host_write(6'd61, 4'h8);
        do_op(6'd60, 6'd61, 6'd62, 1'b1, 1'b0, 4'h3);   // 0xC8: even
        host_write(6'd60, 4'hf); host_write(6'd61, 4'h1);
        do_op(6'd60, 6'd61, 6'd62, 1'b1, 1'b0, 4'h6);   // 0xFF: even
        host_write(6'd60, 4'h4); host_write(6'd61, 4'h4);
        do_op(6'd60, 6'd61, 6'd62, 1'b1, 1'b1, 4'hc);   // 0x10 odd, init forces ext
        do_op(6'd60, 6'd61, 6'd62, 1'b1, 1'b0, 4'hc);   // 0x10 odd, stores 1
        host_write(6'd62, 4'h9);
        do_op(6'd60, 6'd61, 6'd62, 1'b0, 1'b0, 4'h2);   // R9: location keeps 9
        host_write(6'd63, 4'h3);
        do_op(6'd63, 6'd63, 6'd63, 1'b1, 1'b0, 4'hb);   // same source and destination

        for (int i = 0; i < 120; i++) begin
            do_op(6'($urandom), 6'($urandom), 6'($urandom),
                  1'($urandom % 4 != 0), 1'($urandom % 5 == 0), 4'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule